// File: doc/BRIEF.md
# Stack Segment Push/Pop Bound Checker

This block decides whether a stack push or pop of a given byte count may go ahead at the current stack pointer. It looks at the cached attributes of the stack segment descriptor: validity, presence, segment class, code and write permissions, growth direction, operand size, limit and segment end. When the access is not allowed, the block raises a one-cycle stack-fault strobe together with an error code taken from the selector. It performs no address arithmetic for the access itself and does not deliver the fault.

A request is presented for one cycle with `req_valid` high. The verdict is evaluated combinationally and captured in a register, so the fault strobe and its code appear one clock later. All bound arithmetic is carried one bit wider than the address. A subtraction that underflows is therefore seen as a borrow and never wraps into a large value.

Top module: `stack_guard`

## Requirements
- R1: When `prot_mode` is 0 the block never raises `fault_o`, whatever the descriptor and pointer values.
- R2: `fault_o` is registered: it reflects the request presented in the previous cycle, and it is 0 in any cycle that follows a cycle with `req_valid` = 0.
- R3: In protected mode a descriptor with `desc_valid` = 0 or `desc_present` = 0 raises a fault.
- R4: In protected mode a descriptor with `desc_data` = 0 (system segment), `desc_code` = 1 or `desc_wr` = 0 raises a fault.
- R5: While `fault_o` is 1, `fault_code_o` equals the requesting selector with bits [1:0] cleared. While `fault_o` is 0, `fault_code_o` is 0.
- R6: The upper bound is 0x0000FFFF when `desc_big` = 0 and 0xFFFFFFFF when `desc_big` = 1. The pointer is compared unmasked.
- R7: Expand-down push (`desc_down` = 1, `is_push` = 1) faults when the pointer is 0, the pointer is below `acc_len`, pointer − `acc_len` ≤ limit, or the pointer is above the upper bound.
- R8: Expand-up push with pointer 0 faults unless `seg_end` equals the upper bound.
- R9: Expand-up push with a non-zero pointer faults when the pointer is below `acc_len` or when pointer − 1 > limit.
- R10: Expand-down pop faults when the pointer is equal to or above the upper bound, or when (upper bound − pointer + 1) < `acc_len`.
- R11: Expand-up pop faults when the pointer equals the upper bound, `seg_end` is 0, the pointer exceeds the limit, or (limit − pointer + 1) < `acc_len`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | A check request is present this cycle |
| is_push | input | 1 | 1 = push, 0 = pop |
| prot_mode | input | 1 | 1 = protected mode, checks enabled |
| sel_i | input | 16 | Stack segment selector |
| desc_valid | input | 1 | Cached descriptor is loaded |
| desc_present | input | 1 | Segment present |
| desc_data | input | 1 | 1 = code/data segment, 0 = system segment |
| desc_code | input | 1 | 1 = code segment |
| desc_wr | input | 1 | Segment writable |
| desc_down | input | 1 | 1 = expand-down segment |
| desc_big | input | 1 | Default-size bit selecting the 32-bit bound |
| seg_limit | input | 32 | Segment limit |
| seg_end | input | 32 | Segment end address |
| sp_i | input | 32 | Stack pointer |
| acc_len | input | 3 | Access length in bytes (2 or 4) |
| fault_o | output | 1 | Stack-fault strobe, one cycle after the request |
| fault_code_o | output | 16 | Error code for the fault |

## Verification
The only state in the block is the verdict register, so a wrong verdict or a stale code shows at `fault_o` and `fault_code_o` exactly one cycle after the offending request, and never later. The table sweeps each bound formula on both sides of its edge, in both size modes. These points include the pointer-zero wrap case, underflowing subtractions and the pointer-at-bound case. A formula that uses the wrong bound, compares off by one or lets a subtraction wrap therefore flips one of these verdicts. The directed checks confirm that attribute faults take priority over any bound result, and that real mode and idle cycles stay silent.

// File: rtl/stack_guard_pkg.sv
package stack_guard_pkg;
    localparam int ADDR_W  = 32;
    localparam int SEL_W   = 16;
    localparam int LEN_W   = 3;
    localparam int SMALL_W = 16;

    typedef struct packed {
        logic             fault;
        logic [SEL_W-1:0] code;
    } verdict_t;
endpackage

// File: rtl/stack_guard_attr.sv
module stack_guard_attr (
    input  logic desc_valid,
    input  logic desc_present,
    input  logic desc_data,
    input  logic desc_code,
    input  logic desc_wr,
    output logic attr_bad
);
    logic load_bad;
    logic type_bad;

    always_comb begin
        load_bad = !desc_valid || !desc_present;
        type_bad = !desc_data || desc_code || !desc_wr;
        attr_bad = load_bad || type_bad;
    end
endmodule

// File: rtl/stack_guard_bounds.sv
module stack_guard_bounds #(
    parameter int AW      = 32,
    parameter int LW      = 3,
    parameter int SMALL_W = 16
) (
    input  logic          is_push,
    input  logic          desc_down,
    input  logic          desc_big,
    input  logic [AW-1:0] seg_limit,
    input  logic [AW-1:0] seg_end,
    input  logic [AW-1:0] sp_i,
    input  logic [LW-1:0] acc_len,
    output logic          bound_bad
);
    localparam int XW = AW + 1;

    logic [XW-1:0] sp_x, lim_x, end_x, up_x, len_x, one_x;
    logic [XW-1:0] push_rem, push_dec, pop_room_dn, pop_room_up;
    logic          sp_zero, sp_at_up;
    logic          push_dn_bad, push_up_bad, pop_dn_bad, pop_up_bad;

    always_comb begin
        one_x = XW'(1);
        sp_x  = {1'b0, sp_i};
        lim_x = {1'b0, seg_limit};
        end_x = {1'b0, seg_end};
        len_x = {{(XW-LW){1'b0}}, acc_len};
        up_x  = desc_big ? {1'b0, {AW{1'b1}}}
                         : {{(XW-SMALL_W){1'b0}}, {SMALL_W{1'b1}}};

        sp_zero  = (sp_i == '0);
        sp_at_up = (sp_x == up_x);

        push_rem    = sp_x - len_x;
        push_dec    = sp_x - one_x;
        pop_room_dn = up_x - sp_x;
        pop_room_up = lim_x - sp_x;

        push_dn_bad = sp_zero || push_rem[AW] || (push_rem <= lim_x) || (sp_x > up_x);

        if (sp_zero)
            push_up_bad = (end_x != up_x);
        else
            push_up_bad = push_rem[AW] || (push_dec > lim_x);

        pop_dn_bad = sp_at_up || pop_room_dn[AW] || ((pop_room_dn + one_x) < len_x);

        pop_up_bad = sp_at_up || (seg_end == '0) || (sp_x > lim_x)
                     || ((pop_room_up + one_x) < len_x);

        case ({is_push, desc_down})
            2'b11:   bound_bad = push_dn_bad;
            2'b10:   bound_bad = push_up_bad;
            2'b01:   bound_bad = pop_dn_bad;
            default: bound_bad = pop_up_bad;
        endcase
    end
endmodule

// File: rtl/stack_guard.sv
module stack_guard
    import stack_guard_pkg::*;
#(
    parameter int AW = ADDR_W,
    parameter int SW = SEL_W,
    parameter int LW = LEN_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req_valid,
    input  logic          is_push,
    input  logic          prot_mode,
    input  logic [SW-1:0] sel_i,
    input  logic          desc_valid,
    input  logic          desc_present,
    input  logic          desc_data,
    input  logic          desc_code,
    input  logic          desc_wr,
    input  logic          desc_down,
    input  logic          desc_big,
    input  logic [AW-1:0] seg_limit,
    input  logic [AW-1:0] seg_end,
    input  logic [AW-1:0] sp_i,
    input  logic [LW-1:0] acc_len,
    output logic          fault_o,
    output logic [SW-1:0] fault_code_o
);
    typedef struct packed {
        logic          fault;
        logic [SW-1:0] code;
    } state_t;

    logic   attr_bad;
    logic   bound_bad;
    state_t st_d, st_q;

    stack_guard_attr u_attr (
        .desc_valid  (desc_valid),
        .desc_present(desc_present),
        .desc_data   (desc_data),
        .desc_code   (desc_code),
        .desc_wr     (desc_wr),
        .attr_bad    (attr_bad)
    );

    stack_guard_bounds #(
        .AW     (AW),
        .LW     (LW),
        .SMALL_W(SMALL_W)
    ) u_bounds (
        .is_push  (is_push),
        .desc_down(desc_down),
        .desc_big (desc_big),
        .seg_limit(seg_limit),
        .seg_end  (seg_end),
        .sp_i     (sp_i),
        .acc_len  (acc_len),
        .bound_bad(bound_bad)
    );

    always_comb begin
        st_d.fault = req_valid && prot_mode && (attr_bad || bound_bad);
        st_d.code  = st_d.fault ? {sel_i[SW-1:2], 2'b00} : '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            st_q <= '0;
        else
            st_q <= st_d;
    end

    assign fault_o      = st_q.fault;
    assign fault_code_o = st_q.code;
endmodule

// File: rtl/stack_guard_chk.sv
module stack_guard_chk #(
    parameter int SW = 16
) (
    input logic          clk,
    input logic          rst_n,
    input logic          req_valid,
    input logic          prot_mode,
    input logic [SW-1:0] sel_i,
    input logic          desc_valid,
    input logic          desc_present,
    input logic          desc_data,
    input logic          desc_code,
    input logic          desc_wr,
    input logic          fault_o,
    input logic [SW-1:0] fault_code_o
);
    assert_real_mode_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $past(req_valid && !prot_mode) |-> !fault_o);

    assert_idle_low_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(req_valid) |-> !fault_o);

    assert_unloaded_faults_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $past(req_valid && prot_mode && (!desc_valid || !desc_present)) |-> fault_o);

    assert_bad_type_faults_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $past(req_valid && prot_mode && (!desc_data || desc_code || !desc_wr)) |-> fault_o);

    assert_code_from_sel_R5: assert property (@(posedge clk) disable iff (!rst_n)
        fault_o |-> (fault_code_o == {$past(sel_i[SW-1:2]), 2'b00}));

    assert_code_clear_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !fault_o |-> (fault_code_o == '0));
endmodule

bind stack_guard stack_guard_chk #(.SW(SW)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .req_valid   (req_valid),
    .prot_mode   (prot_mode),
    .sel_i       (sel_i),
    .desc_valid  (desc_valid),
    .desc_present(desc_present),
    .desc_data   (desc_data),
    .desc_code   (desc_code),
    .desc_wr     (desc_wr),
    .fault_o     (fault_o),
    .fault_code_o(fault_code_o)
);

// File: tb/stack_guard_tb.sv
module stack_guard_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        is_push = 1'b0;
    logic        prot_mode = 1'b0;
    logic [15:0] sel_i = '0;
    logic        desc_valid = 1'b1;
    logic        desc_present = 1'b1;
    logic        desc_data = 1'b1;
    logic        desc_code = 1'b0;
    logic        desc_wr = 1'b1;
    logic        desc_down = 1'b0;
    logic        desc_big = 1'b0;
    logic [31:0] seg_limit = '0;
    logic [31:0] seg_end = '0;
    logic [31:0] sp_i = '0;
    logic [2:0]  acc_len = 3'd2;
    logic        fault_o;
    logic [15:0] fault_code_o;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #10 clk = ~clk;

    stack_guard u_dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .is_push(is_push),
        .prot_mode(prot_mode), .sel_i(sel_i), .desc_valid(desc_valid),
        .desc_present(desc_present), .desc_data(desc_data), .desc_code(desc_code),
        .desc_wr(desc_wr), .desc_down(desc_down), .desc_big(desc_big),
        .seg_limit(seg_limit), .seg_end(seg_end), .sp_i(sp_i), .acc_len(acc_len),
        .fault_o(fault_o), .fault_code_o(fault_code_o)
    );

    typedef struct packed {
        logic [7:0]  rq;
        logic        push;
        logic        pm;
        logic        big;
        logic        down;
        logic [31:0] sp;
        logic [31:0] lim;
        logic [31:0] send;
        logic [2:0]  len;
        logic        exp;
    } vec_t;

    localparam int NV = 24;
    localparam vec_t VECS [NV] = '{
        '{8'd9,  1'b1,1'b1,1'b0,1'b0, 32'h0000_0100, 32'h0000_FFFF, 32'h0000_FFFF, 3'd2, 1'b0}, // R9
        '{8'd9,  1'b1,1'b1,1'b0,1'b0, 32'h0000_0001, 32'h0000_FFFF, 32'h0000_FFFF, 3'd2, 1'b1}, // R9
        '{8'd9,  1'b1,1'b1,1'b0,1'b0, 32'h0000_2001, 32'h0000_1FFF, 32'h0000_1FFF, 3'd4, 1'b1}, // R9
        '{8'd9,  1'b1,1'b1,1'b0,1'b0, 32'h0000_2000, 32'h0000_1FFF, 32'h0000_1FFF, 3'd4, 1'b0}, // R9
        '{8'd8,  1'b1,1'b1,1'b0,1'b0, 32'h0000_0000, 32'h0000_FFFF, 32'h0000_FFFF, 3'd2, 1'b0}, // R8
        '{8'd8,  1'b1,1'b1,1'b1,1'b0, 32'h0000_0000, 32'h0000_FFFF, 32'h0000_FFFF, 3'd4, 1'b1}, // R8
        '{8'd8,  1'b1,1'b1,1'b1,1'b0, 32'h0000_0000, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 3'd4, 1'b0}, // R8
        '{8'd7,  1'b1,1'b1,1'b0,1'b1, 32'h0000_1000, 32'h0000_0FFC, 32'h0000_FFFF, 3'd4, 1'b1}, // R7
        '{8'd7,  1'b1,1'b1,1'b0,1'b1, 32'h0000_1002, 32'h0000_0FFC, 32'h0000_FFFF, 3'd4, 1'b0}, // R7
        '{8'd7,  1'b1,1'b1,1'b0,1'b1, 32'h0000_0000, 32'h0000_0010, 32'h0000_FFFF, 3'd2, 1'b1}, // R7
        '{8'd6,  1'b1,1'b1,1'b0,1'b1, 32'h0001_0000, 32'h0000_0010, 32'h0000_FFFF, 3'd2, 1'b1}, // R6
        '{8'd6,  1'b1,1'b1,1'b1,1'b1, 32'h0001_0000, 32'h0000_0010, 32'hFFFF_FFFF, 3'd2, 1'b0}, // R6
        '{8'd7,  1'b1,1'b1,1'b0,1'b1, 32'h0000_0003, 32'h0000_0000, 32'h0000_FFFF, 3'd4, 1'b1}, // R7
        '{8'd10, 1'b0,1'b1,1'b0,1'b1, 32'h0000_FFFF, 32'h0000_0010, 32'h0000_FFFF, 3'd2, 1'b1}, // R10
        '{8'd10, 1'b0,1'b1,1'b0,1'b1, 32'h0000_FFFE, 32'h0000_0010, 32'h0000_FFFF, 3'd2, 1'b0}, // R10
        '{8'd10, 1'b0,1'b1,1'b0,1'b1, 32'h0000_FFFE, 32'h0000_0010, 32'h0000_FFFF, 3'd4, 1'b1}, // R10
        '{8'd6,  1'b0,1'b1,1'b1,1'b1, 32'h0000_FFFE, 32'h0000_0010, 32'hFFFF_FFFF, 3'd4, 1'b0}, // R6
        '{8'd10, 1'b0,1'b1,1'b0,1'b1, 32'h0001_2345, 32'h0000_0010, 32'h0000_FFFF, 3'd2, 1'b1}, // R10
        '{8'd11, 1'b0,1'b1,1'b0,1'b0, 32'h0000_0FFC, 32'h0000_0FFF, 32'h0000_0FFF, 3'd4, 1'b0}, // R11
        '{8'd11, 1'b0,1'b1,1'b0,1'b0, 32'h0000_0FFD, 32'h0000_0FFF, 32'h0000_0FFF, 3'd4, 1'b1}, // R11
        '{8'd11, 1'b0,1'b1,1'b0,1'b0, 32'h0000_1000, 32'h0000_0FFF, 32'h0000_0FFF, 3'd2, 1'b1}, // R11
        '{8'd11, 1'b0,1'b1,1'b0,1'b0, 32'h0000_0010, 32'h0000_0FFF, 32'h0000_0000, 3'd2, 1'b1}, // R11
        '{8'd11, 1'b0,1'b1,1'b0,1'b0, 32'h0000_FFFF, 32'h0000_FFFF, 32'h0000_FFFF, 3'd2, 1'b1}, // R11
        '{8'd1,  1'b1,1'b0,1'b0,1'b1, 32'h0000_0000, 32'h0000_0010, 32'h0000_FFFF, 3'd2, 1'b0}  // R1
    };

    task automatic check(input string rq, input logic ef, input logic [15:0] ec);
        checks++;
        if (fault_o !== ef || fault_code_o !== ec) begin
            fails++;
            $display("FAIL %s: fault=%0b code=%h expected fault=%0b code=%h",
                     rq, fault_o, fault_code_o, ef, ec);
        end
    endtask

    task automatic set_attr(input logic v, input logic p, input logic d,
                            input logic c, input logic w);
        desc_valid = v; desc_present = p; desc_data = d; desc_code = c; desc_wr = w;
    endtask

    // Present one request, then sample the registered verdict one cycle later.
    task automatic pulse(input string rq, input logic ef, input logic [15:0] ec);
        @(negedge clk);
        req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        check(rq, ef, ec);
    endtask

    initial begin
        #(20 * 5000);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: run did not finish");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        sel_i = 16'h0013;
        repeat (3) @(negedge clk);
        check("R2 reset", 1'b0, 16'h0000);
        rst_n = 1'b1;
        @(negedge clk);
        check("R2 after reset", 1'b0, 16'h0000);

        for (int i = 0; i < NV; i++) begin
            @(negedge clk);
            is_push = VECS[i].push; prot_mode = VECS[i].pm; desc_big = VECS[i].big;
            desc_down = VECS[i].down; sp_i = VECS[i].sp; seg_limit = VECS[i].lim;
            seg_end = VECS[i].send; acc_len = VECS[i].len;
            pulse($sformatf("R%0d vec%0d", VECS[i].rq, i), VECS[i].exp,
                  VECS[i].exp ? 16'h0010 : 16'h0000);
        end

        // Directed: a benign expand-up push, then spoil one attribute at a time.
        prot_mode = 1'b1; is_push = 1'b1; desc_down = 1'b0; desc_big = 1'b0;
        sp_i = 32'h100; seg_limit = 32'hFFFF; seg_end = 32'hFFFF; acc_len = 3'd2;
        sel_i = 16'hABCF;
        pulse("R5 good path", 1'b0, 16'h0000);
        set_attr(1'b0, 1'b1, 1'b1, 1'b0, 1'b1); pulse("R3 not valid", 1'b1, 16'hABCC);
        set_attr(1'b1, 1'b0, 1'b1, 1'b0, 1'b1); pulse("R3 not present", 1'b1, 16'hABCC);
        set_attr(1'b1, 1'b1, 1'b0, 1'b0, 1'b1); pulse("R4 system seg", 1'b1, 16'hABCC);
        set_attr(1'b1, 1'b1, 1'b1, 1'b1, 1'b1); pulse("R4 code seg", 1'b1, 16'hABCC);
        set_attr(1'b1, 1'b1, 1'b1, 1'b0, 1'b0); pulse("R4 read-only", 1'b1, 16'hABCC);

        // Real mode ignores a bad descriptor.
        prot_mode = 1'b0;
        set_attr(1'b0, 1'b0, 1'b0, 1'b1, 1'b0); pulse("R1 real mode", 1'b0, 16'h0000);

        // No request: bad inputs held but req_valid low.
        prot_mode = 1'b1;
        @(negedge clk);
        @(negedge clk);
        check("R2 idle", 1'b0, 16'h0000);

        // Fault lasts only one cycle after a single request.
        sel_i = 16'h7FFE;
        pulse("R5 code bits", 1'b1, 16'h7FFC);
        @(negedge clk);
        check("R2 one cycle", 1'b0, 16'h0000);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule